// File: doc/BRIEF.md
# Pin-Masked Parallel Port Data Path

This block is the data path of a small parallel I/O port whose register bus uses the word index of each access as a per-pin mask. A write changes only the pins whose mask bit is set and leaves every other output bit as it was. Software can therefore raise or drop one pin, or any group of pins, in a single bus write. It needs no read-modify-write sequence and cannot race another agent driving the same port. A read returns the selected pins in their own bit positions and zero in every other position.

A per-pin direction vector and a per-pin digital-enable vector come from a neighbouring configuration block. For a pin set as an output, a read returns the value held in the output register. For a pin set as an input, a read returns the pad value after a synchronizer, gated by that pin's digital enable. The direction vector also drives the pad output-enables. The electrical behaviour of the pads is handled elsewhere.

Top module: `maskgpio_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `pad_out` is all zeros and `bus_rdata` is all zeros.
- R2: The access word index `bus_idx` is the pin mask: bit i of `bus_idx` selects pin i. Index 0xFF selects the whole port for both reads and writes.
- R3: A write (`bus_sel`=1, `bus_wr`=1) at mask M loads `bus_wdata[i]` into output bit i for every i set in M, and keeps every other output bit unchanged. The new value appears on `pad_out` after the next rising clock edge. Writing 0xFF sets exactly the pins in M, and writing 0x00 clears exactly those pins.
- R4: A write at mask 0x00, and any cycle with no write, leaves `pad_out` unchanged.
- R5: A read (`bus_sel`=1, `bus_wr`=0) at mask M returns 0 in every bit position not set in M.
- R6: For a masked pin whose direction bit is 1 (output), a read returns the output register bit.
- R7: For a masked pin whose direction bit is 0 (input) and whose digital enable is 1, a read returns `pad_in` after a SYNC_STAGES-flop synchronizer. A read issued at any of the first SYNC_STAGES edges after a pad change still returns the old value.
- R8: For a masked pin whose direction bit is 0 and whose digital enable is 0, a read returns 0 whatever the pad level.
- R9: `pad_oe` equals the direction vector `cfg_dir` in the same cycle.
- R10: `bus_rdata` is registered. It takes the read result at the edge that samples the read and holds that value through writes and idle cycles until the next read.
- R11: Writes load the output register whatever the direction setting, so a pin switched to output drives its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | NPINS | Word index inside the data window, used as the pin mask |
| bus_wdata | input | NPINS | Write data, bit i for pin i |
| bus_rdata | output | NPINS | Registered read data, bit i for pin i |
| cfg_dir | input | NPINS | Per-pin direction, 1 = output |
| cfg_den | input | NPINS | Per-pin digital input enable |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Output register value to the pads |
| pad_oe | output | NPINS | Pad output-enables |

## Verification
A write shows on `pad_out` one edge after it is sampled. A read shows on `bus_rdata` one edge after it is sampled. A pad change reaches the read path only after SYNC_STAGES edges. The bench drives every access on a falling edge, releases it on the next falling edge, and compares the outputs there, half a period after the single edge that carries the result. Pad changes are followed by exactly SYNC_STAGES+1 back-to-back reads, which pins the synchronizer latency to the cycle: the early reads must still show the old level.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;
  // Per-pin direction encoding shared by the port and its checker
  typedef enum logic {
    PIN_IS_INPUT  = 1'b0,
    PIN_IS_OUTPUT = 1'b1
  } pin_dir_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/maskgpio_in_sync.sv
module maskgpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/maskgpio_out_reg.sv
module maskgpio_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] out_q
);
  // Bits under the mask come from the new data, the rest from the old value
  function automatic logic [W-1:0] merge_masked(
    input logic [W-1:0] old_v,
    input logic [W-1:0] new_v,
    input logic [W-1:0] m
  );
    return (old_v & ~m) | (new_v & m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       out_q <= '0;
    else if (wr_fire) out_q <= merge_masked(out_q, wr_data, wr_mask);
  end
endmodule

// File: rtl/maskgpio_read_mux.sv
module maskgpio_read_mux
  import maskgpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_fire,
  input  logic [W-1:0] rd_mask,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] den,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] in_sync,
  output logic [W-1:0] rdata_q
);
  logic [W-1:0] pin_view;

  // Output pins show the register, enabled input pins show the pad level
  function automatic logic pin_level(
    input logic d,
    input logic e,
    input logic o,
    input logic i
  );
    if (pin_dir_e'(d) == PIN_IS_OUTPUT) return o;
    return e & i;
  endfunction

  for (genvar p = 0; p < W; p++) begin : g_pin
    assign pin_view[p] = rd_mask[p] & pin_level(dir[p], den[p], out_q[p], in_sync[p]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= pin_view;
  end
endmodule

// File: rtl/maskgpio_port.sv
module maskgpio_port
  import maskgpio_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_idx,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] cfg_dir,
  input  logic [NPINS-1:0] cfg_den,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  localparam int unsigned SYNC_N =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  // Named internal events, also seen by the bound checker
  logic             wr_fire;
  logic             rd_fire;
  logic [NPINS-1:0] acc_mask;
  logic [NPINS-1:0] in_sync;

  assign wr_fire  = bus_sel &  bus_wr;
  assign rd_fire  = bus_sel & ~bus_wr;
  assign acc_mask = bus_idx;
  assign pad_oe   = cfg_dir;

  maskgpio_in_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (in_sync)
  );

  maskgpio_out_reg #(.W(NPINS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_mask (acc_mask),
    .wr_data (bus_wdata),
    .out_q   (pad_out)
  );

  maskgpio_read_mux #(.W(NPINS)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .rd_mask (acc_mask),
    .dir     (cfg_dir),
    .den     (cfg_den),
    .out_q   (pad_out),
    .in_sync (in_sync),
    .rdata_q (bus_rdata)
  );
endmodule

// File: rtl/maskgpio_checker.sv
module maskgpio_checker #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic [NPINS-1:0] acc_mask,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] cfg_dir,
  input logic [NPINS-1:0] cfg_den,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] bus_rdata
);
  // R3: bits outside the mask keep their value across a write
  a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((pad_out & ~$past(acc_mask)) == ($past(pad_out) & ~$past(acc_mask))));

  // R3: bits under the mask take the write data
  a_r3_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((pad_out & $past(acc_mask)) == ($past(bus_wdata) & $past(acc_mask))));

  // R4: no write, no output change
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(pad_out));

  // R5: unmasked read bits are zero
  a_r5_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ((bus_rdata & ~$past(acc_mask)) == '0));

  // R6: masked output pins read the output register
  a_r6_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ((bus_rdata & $past(acc_mask & cfg_dir)) ==
                 ($past(pad_out) & $past(acc_mask & cfg_dir))));

  // R8: disabled input pins read zero
  a_r8_den_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ((bus_rdata & $past(~cfg_dir & ~cfg_den)) == '0));

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(bus_rdata));
endmodule

bind maskgpio_port maskgpio_checker #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_fire   (wr_fire),
  .rd_fire   (rd_fire),
  .acc_mask  (acc_mask),
  .bus_wdata (bus_wdata),
  .cfg_dir   (cfg_dir),
  .cfg_den   (cfg_den),
  .pad_out   (pad_out),
  .bus_rdata (bus_rdata)
);

// File: tb/maskgpio_port_test.sv
`timescale 1ns/1ps
module maskgpio_port_test;
  localparam int unsigned N    = 8;
  localparam int unsigned SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_sel, bus_wr;
  logic [N-1:0] bus_idx, bus_wdata, bus_rdata;
  logic [N-1:0] cfg_dir, cfg_den, pad_in, pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] model_out;

  always #2.5 clk = ~clk;

  maskgpio_port #(.NPINS(N), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_dir(cfg_dir), .cfg_den(cfg_den), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start just after a falling edge and end just after one
  task automatic wr(input logic [N-1:0] m, input logic [N-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = m; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_out = (model_out & ~m) | (d & m);
  endtask

  task automatic rd(input logic [N-1:0] m);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = m;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [N-1:0] expect_read(input logic [N-1:0] m,
    input logic [N-1:0] d, input logic [N-1:0] e, input logic [N-1:0] o,
    input logic [N-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = m[i] & (d[i] ? o[i] : (e[i] & p[i]));
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] held, old_pin;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_idx = '0; bus_wdata = '0;
    cfg_dir = '0; cfg_den = '0; pad_in = 8'hFF; model_out = '0;
    idle(3);
    chk("R1 reset pad_out", pad_out, 8'h00);
    chk("R1 reset rdata", bus_rdata, 8'h00);
    rst_n = 1'b1;
    idle(1);
    chk("R1 after release pad_out", pad_out, 8'h00);
    chk("R1 after release rdata", bus_rdata, 8'h00);

    // R9: output-enables follow direction
    cfg_dir = 8'hA5; #1 chk("R9 oe A5", pad_oe, 8'hA5);
    cfg_dir = 8'h3C; #1 chk("R9 oe 3C", pad_oe, 8'h3C);
    idle(1);

    // R2/R3/R4: sweep every mask with shifting data
    cfg_dir = 8'hFF; cfg_den = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      wr(N'(m), N'(m * 37 + 11));
      chk(m == 0 ? "R4 mask zero write" : "R3 R2 masked write", pad_out, model_out);
    end
    wr(8'hFF, 8'h00);
    chk("R2 whole-port clear", pad_out, 8'h00);
    wr(8'h24, 8'hFF);
    chk("R3 set only masked pins", pad_out, 8'h24);
    wr(8'h81, 8'hFF);
    chk("R3 set adds pins", pad_out, 8'hA5);
    wr(8'h04, 8'h00);
    chk("R3 clear one pin", pad_out, 8'hA1);
    idle(4);
    chk("R4 idle hold", pad_out, 8'hA1);

    // R5/R6: output readback at every mask
    for (int m = 0; m < 256; m++) begin
      rd(N'(m));
      chk("R5 R6 output readback", bus_rdata, model_out & N'(m));
    end

    // R11: writes with pins as inputs still load the register
    cfg_dir = 8'h00;
    wr(8'hFF, 8'h5A);
    chk("R11 write while input", pad_out, 8'h5A);
    cfg_dir = 8'hFF;
    rd(8'hFF);
    chk("R11 readback after turn to output", bus_rdata, 8'h5A);

    // R7/R8: mixed directions and enables, all masks
    cfg_dir = 8'h0F; cfg_den = 8'h3F; pad_in = 8'hC6;
    idle(SYNC + 1);
    for (int m = 0; m < 256; m++) begin
      rd(N'(m));
      chk("R7 R8 R5 mixed read", bus_rdata,
          expect_read(N'(m), cfg_dir, cfg_den, model_out, pad_in));
    end

    // R7: synchronizer latency, exactly SYNC stale reads
    old_pin = pad_in;
    pad_in = 8'h39;
    for (int k = 0; k <= int'(SYNC); k++) begin
      rd(8'hFF);
      chk(k < int'(SYNC) ? "R7 stale during sync" : "R7 new after sync", bus_rdata,
          expect_read(8'hFF, cfg_dir, cfg_den, model_out, (k < int'(SYNC)) ? old_pin : pad_in));
    end

    // R8: disabled inputs read zero with pads high
    cfg_dir = 8'h00; cfg_den = 8'h00; pad_in = 8'hFF;
    idle(SYNC + 1);
    rd(8'hFF);
    chk("R8 disabled inputs", bus_rdata, 8'h00);

    // R10: read data holds through writes and idle
    cfg_dir = 8'hFF;
    rd(8'hF0);
    held = model_out & 8'hF0;
    chk("R10 read capture", bus_rdata, held);
    wr(8'hFF, ~model_out);
    chk("R10 hold over write", bus_rdata, held);
    idle(3);
    chk("R10 hold over idle", bus_rdata, held);

    finish_run();
  end
endmodule